// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block turns one host request for PCI configuration space into the two actions a host bridge needs: a value for the bridge's outbound window register and a 32-bit local bus address inside the configuration aperture. A request names the target bus, device, function, register offset, transfer size and direction. Requests for bus 0 become Type 0 cycles, where the device is selected by a single address line (IDSEL). Requests for any other bus become Type 1 cycles, where the bus, device and function are encoded in the address.

The downstream side is a plain 32-bit word port with a request/acknowledge handshake and an error flag. Reads of one or two bytes return the addressed lanes moved down to bit 0. Writes narrower than a word are performed as a read of the word, a lane merge and a write back. One request is in flight at a time. When it ends, the block pulses `done` together with a status code.

Top module: `pci_cfg_xlate`

## Requirements
- R1: The accepted sizes are 1, 2 and 4 bytes. Any other size ends with status 2'b10 (bad size), with no window write and no downstream access. This check is made before any device check.
- R2: Bus 0 selects a Type 0 access. Any other bus selects a Type 1 access.
- R3: On bus 0, a device number of 16 or above ends with status 2'b01 (not found), with no window write and no downstream access.
- R4: While `cardbus_mode` is high, a device number above 1 ends with status 2'b01, with no access, on any bus.
- R5: For Type 0, IDSEL is the single bit at position device+16. The window value is 32'h0000_0002 OR'd with the part of IDSEL in bits 31:26. The address is 32'h0C00_0000 OR'd with the part of IDSEL in bits 25:16, the function in bits 10:8, and offset bits 7:2 in address bits 7:2.
- R6: For Type 1, the window value is 32'h0000_0003. The address is 32'h0C00_0000 with the bus in bits 23:16, the device in 15:11, the function in 10:8, offset bits 7:2 in bits 7:2, and bits 1:0 set to 01.
- R7: Read data is the fetched word shifted right by 8×(offset mod 4). It is then masked to 8 bits for size 1 or 16 bits for size 2, and is returned with status 2'b00.
- R8: A 1- or 2-byte write reads the word, replaces only the addressed lanes (byte lane n = bits 8n+7:8n) with the new data, and writes the word back.
- R9: A 4-byte write makes exactly one downstream write, with no read, and stores the data unchanged.
- R10: After reset, `busy`, `done`, `win_we` and `ds_req` are low. `busy` is high from the cycle after acceptance until `done`. `done` lasts one cycle. `req_valid` is ignored while `busy` is high.
- R11: An error flagged with the acknowledge of a downstream read ends the request with status 2'b01, and no write follows.
- R12: The window register is written exactly once per valid request, in a one-cycle `win_we` pulse before the first downstream access. `ds_req` and the access fields stay steady until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cardbus_mode | input | 1 | Restricts valid devices to 0 and 1 |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Transfer size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 ok, 01 not found, 10 bad size |
| rdata | output | 32 | Aligned read data, valid with done |
| win_we | output | 1 | Window register write strobe |
| win_data | output | 32 | Window register value |
| ds_req | output | 1 | Downstream access request |
| ds_write | output | 1 | Downstream access is a write |
| ds_addr | output | 32 | Downstream word address |
| ds_wdata | output | 32 | Downstream write word |
| ds_ack | input | 1 | Downstream acknowledge |
| ds_rdata | input | 32 | Downstream read word |
| ds_err | input | 1 | Bus error with the acknowledge |

## Verification
The assertions rely on the downstream port raising `ds_ack` only while `ds_req` is high, and for a single cycle per access. They also rely on `ds_err` being meaningful only in that acknowledge cycle. The bench's responder acknowledges exactly one cycle after it first sees a request and then drops the acknowledge. It asserts the error only on reads, and only while a test has armed it. The bench raises requests for one cycle while the block is idle, except for the scenario that holds `req_valid` high during `busy` on purpose.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int OFF_W  = 8;
  localparam int SIZE_W = 3;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    CFG_OK      = 2'b00,
    CFG_NODEV   = 2'b01,
    CFG_BADSIZE = 2'b10
  } cfg_status_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CHECK,
    SQ_WIN,
    SQ_RD,
    SQ_WR,
    SQ_DONE
  } seq_state_e;

  typedef struct packed {
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic [OFF_W-1:0]  off;
    logic [SIZE_W-1:0] size;
    logic              wr;
    logic [DATA_W-1:0] wdata;
  } cfg_req_t;

endpackage

// File: rtl/cfgx_route.sv
module cfgx_route
  import cfgx_pkg::*;
#(
  parameter int          SLOT_LIMIT = 16,
  parameter int          IDSEL_LSB  = 16,
  parameter logic [31:0] WIN_MASK   = 32'hFC00_0000,
  parameter logic [31:0] CFG_BASE   = 32'h0C00_0000,
  parameter logic [31:0] T0_CODE    = 32'h0000_0002,
  parameter logic [31:0] T1_CODE    = 32'h0000_0003
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FUNC_W-1:0] func,
  input  logic [OFF_W-3:0]  dword,
  input  logic [SIZE_W-1:0] size,
  input  logic              cardbus,
  output logic              size_ok,
  output logic              present,
  output logic              type1,
  output logic [31:0]       win_value,
  output logic [31:0]       addr
);

  localparam int SH_W = 6;

  logic [SH_W-1:0] sel_pos;
  logic [31:0]     idsel;
  logic [31:0]     t0_addr;
  logic [31:0]     t1_addr;

  assign sel_pos = SH_W'(dev) + SH_W'(IDSEL_LSB);

  // one-hot decode of the device select line
  for (genvar g = 0; g < 32; g++) begin : g_idsel
    assign idsel[g] = (sel_pos == SH_W'(g));
  end

  always_comb begin
    size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    type1   = (bus != '0);
    present = 1'b1;
    if (cardbus && (dev > 5'd1))
      present = 1'b0;
    if (!type1 && (32'(dev) >= SLOT_LIMIT))
      present = 1'b0;
  end

  always_comb begin
    t0_addr = CFG_BASE | (idsel & ~WIN_MASK)
            | {21'b0, func, dword, 2'b00};
    t1_addr = CFG_BASE | {8'b0, bus, dev, func, dword, 2'b01};
    if (type1) begin
      win_value = T1_CODE;
      addr      = t1_addr;
    end else begin
      win_value = T0_CODE | (idsel & WIN_MASK);
      addr      = t0_addr;
    end
  end

endmodule

// File: rtl/cfgx_lanes.sv
module cfgx_lanes
  import cfgx_pkg::*;
#(
  parameter int LANES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] word,
  input  logic [1:0]        lane,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_aligned,
  output logic [DATA_W-1:0] wr_merged
);

  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] size_mask;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] new_bits;

  assign shamt = {lane, 3'b000};

  always_comb begin
    case (size)
      3'd1:    size_mask = DATA_W'(32'h0000_00FF);
      3'd2:    size_mask = DATA_W'(32'h0000_FFFF);
      default: size_mask = '1;
    endcase
    lane_mask  = size_mask << shamt;
    new_bits   = (wdata & size_mask) << shamt;
    rd_aligned = (word >> shamt) & size_mask;
  end

  // per-lane merge: take the new byte where the lane is targeted
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign wr_merged[8*b +: 8] = lane_mask[8*b] ? new_bits[8*b +: 8]
                                                : word[8*b +: 8];
  end

endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
  import cfgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              size_ok,
  input  logic              present,
  input  logic              is_write,
  input  logic              full_write,
  input  logic              ds_ack,
  input  logic              ds_err,
  input  logic [DATA_W-1:0] ds_rdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic              win_we,
  output logic              ds_req,
  output logic              ds_write,
  output logic [DATA_W-1:0] word
);

  seq_state_e        state_q, state_d;
  cfg_status_e       stat_q, stat_d;
  logic [DATA_W-1:0] word_q;
  logic              word_en;

  always_comb begin
    state_d = state_q;
    stat_d  = stat_q;
    word_en = 1'b0;
    case (state_q)
      SQ_IDLE:  if (start) state_d = SQ_CHECK;
      SQ_CHECK: begin
        if (!size_ok) begin
          state_d = SQ_DONE;
          stat_d  = CFG_BADSIZE;
        end else if (!present) begin
          state_d = SQ_DONE;
          stat_d  = CFG_NODEV;
        end else begin
          state_d = SQ_WIN;
          stat_d  = CFG_OK;
        end
      end
      SQ_WIN:   state_d = full_write ? SQ_WR : SQ_RD;
      SQ_RD: begin
        if (ds_ack) begin
          if (ds_err) begin
            state_d = SQ_DONE;
            stat_d  = CFG_NODEV;
          end else begin
            word_en = 1'b1;
            state_d = is_write ? SQ_WR : SQ_DONE;
          end
        end
      end
      SQ_WR:    if (ds_ack) state_d = SQ_DONE;
      SQ_DONE:  state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      stat_q  <= CFG_OK;
    end else begin
      state_q <= state_d;
      stat_q  <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      word_q <= '0;
    else if (word_en)
      word_q <= ds_rdata;
  end

  assign busy     = (state_q != SQ_IDLE);
  assign done     = (state_q == SQ_DONE);
  assign status   = stat_q;
  assign win_we   = (state_q == SQ_WIN);
  assign ds_req   = (state_q == SQ_RD) || (state_q == SQ_WR);
  assign ds_write = (state_q == SQ_WR);
  assign word     = word_q;

  // R1: a bad size never reaches the window or the port
  p_badsize_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_CHECK && !size_ok) |=> (!win_we && !ds_req && done));

  // R3 / R4: absent device ends with not-found and no access
  p_absent_nodev_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_CHECK && size_ok && !present)
      |=> (done && status == CFG_NODEV && !win_we));

  // R9: full write skips the read
  p_full_write_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && full_write) |=> (ds_req && ds_write));

  // R11: read error ends the request with no write
  p_err_skips_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req && !ds_write && ds_ack && ds_err)
      |=> (done && !ds_req && status == CFG_NODEV));

  // R10: done is a single pulse that returns to idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R12: window written just before an access starts, access held until ack
  p_win_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ds_req) |-> $past(win_we));
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req && !ds_ack) |=> (ds_req && $stable(ds_write)));

endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
  import cfgx_pkg::*;
#(
  parameter int          SLOT_LIMIT = 16,
  parameter int          IDSEL_LSB  = 16,
  parameter logic [31:0] WIN_MASK   = 32'hFC00_0000,
  parameter logic [31:0] CFG_BASE   = 32'h0C00_0000,
  parameter logic [31:0] T0_CODE    = 32'h0000_0002,
  parameter logic [31:0] T1_CODE    = 32'h0000_0003,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cardbus_mode,
  input  logic        req_valid,
  input  logic [7:0]  req_bus,
  input  logic [4:0]  req_dev,
  input  logic [2:0]  req_func,
  input  logic [7:0]  req_off,
  input  logic [2:0]  req_size,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [1:0]  status,
  output logic [31:0] rdata,
  output logic        win_we,
  output logic [31:0] win_data,
  output logic        ds_req,
  output logic        ds_write,
  output logic [31:0] ds_addr,
  output logic [31:0] ds_wdata,
  input  logic        ds_ack,
  input  logic [31:0] ds_rdata,
  input  logic        ds_err
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;
  cfg_req_t               req_q, req_d;
  logic                   accept;
  logic                   size_ok, present, type1;
  logic                   full_write;
  logic [DATA_W-1:0]      word, merged;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= '0;
    else
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  assign accept = req_valid && !busy;

  always_comb begin
    req_d       = req_q;
    if (accept) begin
      req_d.bus   = req_bus;
      req_d.dev   = req_dev;
      req_d.func  = req_func;
      req_d.off   = req_off;
      req_d.size  = req_size;
      req_d.wr    = req_write;
      req_d.wdata = req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)
      req_q <= '0;
    else
      req_q <= req_d;
  end

  assign full_write = req_q.wr && (req_q.size == 3'd4);

  cfgx_route #(
    .SLOT_LIMIT (SLOT_LIMIT),
    .IDSEL_LSB  (IDSEL_LSB),
    .WIN_MASK   (WIN_MASK),
    .CFG_BASE   (CFG_BASE),
    .T0_CODE    (T0_CODE),
    .T1_CODE    (T1_CODE)
  ) u_route (
    .bus       (req_q.bus),
    .dev       (req_q.dev),
    .func      (req_q.func),
    .dword     (req_q.off[OFF_W-1:2]),
    .size      (req_q.size),
    .cardbus   (cardbus_mode),
    .size_ok   (size_ok),
    .present   (present),
    .type1     (type1),
    .win_value (win_data),
    .addr      (ds_addr)
  );

  cfgx_lanes u_lanes (
    .word       (word),
    .lane       (req_q.off[1:0]),
    .size       (req_q.size),
    .wdata      (req_q.wdata),
    .rd_aligned (rdata),
    .wr_merged  (merged)
  );

  cfgx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (accept),
    .size_ok    (size_ok),
    .present    (present),
    .is_write   (req_q.wr),
    .full_write (full_write),
    .ds_ack     (ds_ack),
    .ds_err     (ds_err),
    .ds_rdata   (ds_rdata),
    .busy       (busy),
    .done       (done),
    .status     (status),
    .win_we     (win_we),
    .ds_req     (ds_req),
    .ds_write   (ds_write),
    .word       (word)
  );

  assign ds_wdata = full_write ? req_q.wdata : merged;

  // R5: Type 0 select line appears in exactly one place, window or address
  p_idsel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (win_we && !type1)
      |-> ($countones(win_data & WIN_MASK)
           + $countones(ds_addr & ~WIN_MASK & 32'hFFFF_0000) == 1));

  // R2: Type 1 window carries the fixed code only
  p_type1_code_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (win_we && type1) |-> (win_data == T1_CODE && ds_addr[1:0] == 2'b01));

  // R10: a request seen while busy leaves the held request untouched
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (busy && req_valid) |=> $stable(req_q));

endmodule

// File: tb/test_pci_cfg_xlate.sv
`timescale 1ns/1ps
module test_pci_cfg_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cardbus_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [7:0]  req_off = '0;
  logic [2:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, win_we, ds_req, ds_write;
  logic [1:0]  status;
  logic [31:0] rdata, win_data, ds_addr, ds_wdata;
  logic        ds_ack = 1'b0;
  logic [31:0] ds_rdata = '0;
  logic        ds_err = 1'b0;

  always #5 clk = ~clk;

  pci_cfg_xlate i_pci_cfg_xlate (
    .clk(clk), .rst_n(rst_n), .cardbus_mode(cardbus_mode),
    .req_valid(req_valid), .req_bus(req_bus), .req_dev(req_dev),
    .req_func(req_func), .req_off(req_off), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata),
    .busy(busy), .done(done), .status(status), .rdata(rdata),
    .win_we(win_we), .win_data(win_data),
    .ds_req(ds_req), .ds_write(ds_write), .ds_addr(ds_addr),
    .ds_wdata(ds_wdata), .ds_ack(ds_ack), .ds_rdata(ds_rdata),
    .ds_err(ds_err)
  );

  // downstream responder: acknowledges one cycle after a request appears
  logic [31:0] mem [0:15];
  logic        err_arm = 1'b0;
  int          rd_cnt = 0, wr_cnt = 0, win_cnt = 0, cyc = 0;
  int          win_cyc = 0, acc_cyc = 0;
  logic [31:0] win_last = '0, addr_last = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (win_we) begin
      win_last <= win_data;
      win_cnt  <= win_cnt + 1;
      win_cyc  <= cyc;
    end
    if (ds_req && !ds_ack) begin
      ds_ack    <= 1'b1;
      addr_last <= ds_addr;
      acc_cyc   <= cyc;
      ds_rdata  <= mem[ds_addr[5:2]];
      ds_err    <= err_arm && !ds_write;
      if (ds_write) begin
        mem[ds_addr[5:2]] <= ds_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end else begin
      ds_ack <= 1'b0;
      ds_err <= 1'b0;
    end
  end

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] t0_win(input int dev);
    logic [31:0] sel = 32'(64'(1) << (dev + 16));
    return 32'h2 | (sel & 32'hFC00_0000);
  endfunction

  function automatic logic [31:0] t0_addr(input int dev, input int func, input int off);
    logic [31:0] sel = 32'(64'(1) << (dev + 16));
    return 32'h0C00_0000 | (sel & 32'h03FF_0000) | 32'(func << 8) | 32'(off & 8'hFC);
  endfunction

  function automatic logic [31:0] t1_addr(input int bus, input int dev, input int func, input int off);
    return 32'h0C00_0000 | 32'(bus << 16) | 32'(dev << 11) | 32'(func << 8)
         | 32'(off & 8'hFC) | 32'h1;
  endfunction

  logic [1:0]  r_st;
  logic [31:0] r_rd;
  int          d_rd, d_wr, d_win;

  task automatic run(input int bus, input int dev, input int func, input int off,
                     input int size, input bit wr, input logic [31:0] wd, input int hold);
    int r0 = rd_cnt, w0 = wr_cnt, n0 = win_cnt;
    bit seen = 0;
    @(negedge clk);
    req_bus = 8'(bus); req_dev = 5'(dev); req_func = 3'(func);
    req_off = 8'(off); req_size = 3'(size); req_write = wr; req_wdata = wd;
    req_valid = 1'b1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      req_dev = 5'(dev + 1);
    end
    req_valid = 1'b0;
    for (int t = 0; t < 40 && !seen; t++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    if (!seen) begin
      n_cmp++; n_bad++;
      $display("FAIL R10: actual no done expected done");
    end
    r_st = status; r_rd = rdata;
    @(negedge clk);
    d_rd = rd_cnt - r0; d_wr = wr_cnt - w0; d_win = win_cnt - n0;
  endtask

  task automatic t_reset;
    chk("R10 busy at reset", 32'(busy), 0);
    chk("R10 done at reset", 32'(done), 0);
    chk("R10 win_we at reset", 32'(win_we), 0);
    chk("R10 ds_req at reset", 32'(ds_req), 0);
  endtask

  task automatic t_type0_low;
    mem[3] = 32'hA1B2_C3D4;
    run(0, 3, 1, 8'h0E, 2, 0, 0, 1);
    chk("R7 status", 32'(r_st), 0);
    chk("R5 window dev3", win_last, t0_win(3));
    chk("R5 address dev3", addr_last, t0_addr(3, 1, 8'h0E));
    chk("R7 half read lane2", r_rd, 32'h0000_A1B2);
    chk("R12 one window write", 32'(d_win), 1);
    chk("R12 window before access", 32'(win_cyc < acc_cyc), 1);
    mem[2] = 32'h1122_3344;
    run(0, 0, 0, 8'h09, 1, 0, 0, 1);
    chk("R7 byte read lane1", r_rd, 32'h0000_0033);
  endtask

  task automatic t_type0_high;
    mem[1] = 32'h5566_7788;
    run(0, 12, 0, 8'h04, 4, 0, 0, 1);
    chk("R5 window dev12", win_last, t0_win(12));
    chk("R5 address dev12", addr_last, t0_addr(12, 0, 8'h04));
    chk("R7 word read", r_rd, 32'h5566_7788);
  endtask

  task automatic t_type0_absent;
    run(0, 16, 0, 0, 4, 0, 0, 1);
    chk("R3 status dev16", 32'(r_st), 1);
    chk("R3 no window", 32'(d_win), 0);
    chk("R3 no access", 32'(d_rd + d_wr), 0);
  endtask

  task automatic t_type1;
    mem[0] = 32'hCAFE_F00D;
    run(2, 5, 3, 8'h40, 4, 0, 0, 1);
    chk("R2 R6 window code", win_last, 32'h3);
    chk("R6 address", addr_last, t1_addr(2, 5, 3, 8'h40));
    chk("R6 read data", r_rd, 32'hCAFE_F00D);
    run(1, 20, 0, 8'h00, 4, 0, 0, 1);
    chk("R2 bus1 dev20 present", 32'(r_st), 0);
    chk("R6 address dev20", addr_last, t1_addr(1, 20, 0, 0));
  endtask

  task automatic t_badsize;
    run(0, 1, 0, 0, 3, 0, 0, 1);
    chk("R1 size3 status", 32'(r_st), 2);
    chk("R1 size3 no access", 32'(d_rd + d_wr + d_win), 0);
    run(0, 20, 0, 0, 0, 1, 32'h1, 1);
    chk("R1 size before device", 32'(r_st), 2);
    chk("R1 size0 no access", 32'(d_rd + d_wr + d_win), 0);
  endtask

  task automatic t_subword_write;
    mem[1] = 32'h1122_3344;
    run(0, 2, 0, 8'h05, 1, 1, 32'hFFFF_FFAB, 1);
    chk("R8 byte merge", mem[1], 32'h1122_AB44);
    chk("R8 byte read count", 32'(d_rd), 1);
    chk("R8 byte write count", 32'(d_wr), 1);
    mem[0] = 32'h1122_5566;
    run(3, 0, 0, 8'h02, 2, 1, 32'h0000_BEEF, 1);
    chk("R8 half merge", mem[0], 32'hBEEF_5566);
  endtask

  task automatic t_full_write;
    mem[4] = 32'h0;
    run(0, 4, 0, 8'h10, 4, 1, 32'hDEAD_BEEF, 1);
    chk("R9 stored", mem[4], 32'hDEAD_BEEF);
    chk("R9 no read", 32'(d_rd), 0);
    chk("R9 one write", 32'(d_wr), 1);
    chk("R12 window before write", 32'(win_cyc < acc_cyc), 1);
  endtask

  task automatic t_cardbus;
    cardbus_mode = 1'b1;
    run(0, 2, 0, 0, 4, 0, 0, 1);
    chk("R4 dev2 rejected", 32'(r_st), 1);
    chk("R4 no access", 32'(d_rd + d_wr + d_win), 0);
    run(4, 2, 0, 0, 4, 0, 0, 1);
    chk("R4 dev2 rejected type1", 32'(r_st), 1);
    run(0, 1, 0, 0, 4, 0, 0, 1);
    chk("R4 dev1 allowed", 32'(r_st), 0);
    cardbus_mode = 1'b0;
  endtask

  task automatic t_bus_error;
    mem[5] = 32'h7777_7777;
    err_arm = 1'b1;
    run(0, 6, 0, 8'h14, 1, 1, 32'h11, 1);
    err_arm = 1'b0;
    chk("R11 status", 32'(r_st), 1);
    chk("R11 no write", 32'(d_wr), 0);
    chk("R11 memory kept", mem[5], 32'h7777_7777);
  endtask

  task automatic t_busy;
    mem[6] = 32'h0102_0304;
    run(0, 7, 0, 8'h18, 4, 0, 0, 4);
    chk("R10 one window while busy", 32'(d_win), 1);
    chk("R10 first request kept", win_last, t0_win(7));
    chk("R10 first address kept", addr_last, t0_addr(7, 0, 8'h18));
    chk("R10 idle after done", 32'(busy), 0);
    chk("R10 done pulse ended", 32'(done), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_type0_low();
    t_type0_high();
    t_type0_absent();
    t_type1();
    t_badsize();
    t_subword_write();
    t_full_write();
    t_cardbus();
    t_bus_error();
    t_busy();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule